// File: doc/BRIEF.md
# Single-Address Accumulator Processor

A compact word-addressed processor that executes one-address instructions from a unified 4K-word memory. Program and data share this memory. Each 16-bit instruction word holds a 4-bit operation code in bits 15:12 and a 12-bit operand address in bits 11:0. The operand is always the word stored at that address, never the address value itself. Intermediate sums stay in a single 16-bit accumulator.

Six operations are recognised. Three use the accumulator: load it, add to it, or store it. READ copies one word from a valid/ready input port into memory. PRINT sends one memory word to a valid/ready output port. HALT stops the machine. The processor uses a synchronous memory port: read data appears one clock after the address is presented. An active-low reset restarts execution at a start address set by a parameter.

Top module: `accum_core`

## Requirements
- R1: While `rstN` is low, `halted`, `inReady`, `outValid` and `memWe` are 0. In the first cycle after release, `memAddr` presents the start address (default 0x008) as an instruction fetch. The accumulator resets to 0.
- R2: An instruction word carries its operation code in bits 15:12 and its operand address in bits 11:0. Instructions execute from successive addresses, and the program counter advances by exactly one after each instruction. A word written by one instruction into the next instruction's location is the word that executes next.
- R3: Code 0x1 replaces the whole accumulator with the memory word at the operand address. No earlier accumulator contents survive.
- R4: Code 0x2 adds the memory word at the operand address to the accumulator, modulo 2^16, with no carry kept.
- R5: Code 0x6 writes the accumulator to the operand address and leaves the accumulator unchanged.
- R6: Code 0xA raises `inReady` and waits with no memory write and no instruction fetch until `inValid` is high. In that handshake cycle it writes `inData` to the operand address.
- R7: Code 0xB raises `outValid` with the memory word at the operand address on `outData`. It holds both stable until `outReady` is high, and only then continues.
- R8: Code 0xF sets `halted`, whatever the operand field holds. From then until reset there are no memory writes, no fetches and no handshakes.
- R9: Any other operation code performs no memory write and leaves the accumulator unchanged. It only advances the program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset; release starts execution |
| memAddr | output | 12 | Word address to memory (read every cycle, written when memWe) |
| memWe | output | 1 | Memory write enable |
| memWdata | output | 16 | Memory write data |
| memRdata | input | 16 | Memory read data, one cycle after memAddr |
| inValid | input | 1 | Input word available |
| inReady | output | 1 | Processor is waiting in a READ |
| inData | input | 16 | Input word |
| outValid | output | 1 | Output word available from a PRINT |
| outReady | input | 1 | Output consumer accepts the word |
| outData | output | 16 | Output word |
| halted | output | 1 | Processor has executed HALT |

## Verification
A READ handshake does two things on the same clock edge: it writes the input word to memory and it advances the program counter. The bench provokes both at once with a READ whose operand address is the very next instruction location. It then feeds in a PRINT instruction word, and the word printed must be the one that PRINT addresses. A second overlap arises when a stall ends on the same edge as the next fetch. Randomly delayed input and output handshakes exercise this case. The bench judges it by checking that the address and output data stay frozen during each stall, and that the final sums match independently computed values.

// File: rtl/accum_pkg.sv
package accum_pkg;

  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OP_LOAD  = 4'h1;
  localparam logic [OP_W-1:0] OP_ADD   = 4'h2;
  localparam logic [OP_W-1:0] OP_STORE = 4'h6;
  localparam logic [OP_W-1:0] OP_READ  = 4'hA;
  localparam logic [OP_W-1:0] OP_PRINT = 4'hB;
  localparam logic [OP_W-1:0] OP_HALT  = 4'hF;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_DECODE,
    ST_OPER,
    ST_INPUT,
    ST_OUTPUT,
    ST_HALT
  } cpuState_e;

  typedef enum logic [1:0] {
    ADDR_PC,
    ADDR_FETCHED,
    ADDR_IR
  } addrSel_e;

  typedef struct packed {
    logic     irLoad;
    logic     accLoad;
    logic     accAdd;
    logic     pcInc;
    logic     outLoad;
    logic     memWe;
    logic     wrFromIn;
    addrSel_e addrSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/accum_ctrl.sv
module accum_ctrl
  import accum_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [OP_W-1:0]   fetchOp,
  input  logic [OP_W-1:0]   irOp,
  input  logic              inValid,
  input  logic              outReady,
  output ctrlStrobe_t       strobe,
  output logic              inReady,
  output logic              outValid,
  output logic              halted
);

  cpuState_e curState;
  cpuState_e nxtState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curState <= ST_FETCH;
    else       curState <= nxtState;
  end

  always_comb begin
    strobe   = '0;
    strobe.addrSel = ADDR_PC;
    nxtState = curState;
    inReady  = 1'b0;
    outValid = 1'b0;
    halted   = 1'b0;
    unique case (curState)
      ST_FETCH: begin
        strobe.addrSel = ADDR_PC;
        nxtState = ST_DECODE;
      end
      ST_DECODE: begin
        // memRdata carries the instruction word in this cycle
        strobe.irLoad  = 1'b1;
        strobe.addrSel = ADDR_FETCHED;
        unique case (fetchOp)
          OP_LOAD, OP_ADD, OP_PRINT: nxtState = ST_OPER;
          OP_STORE: begin
            strobe.memWe = 1'b1;
            strobe.pcInc = 1'b1;
            nxtState     = ST_FETCH;
          end
          OP_READ: nxtState = ST_INPUT;
          OP_HALT: nxtState = ST_HALT;
          default: begin
            strobe.pcInc = 1'b1;
            nxtState     = ST_FETCH;
          end
        endcase
      end
      ST_OPER: begin
        // memRdata carries the operand word in this cycle
        strobe.addrSel = ADDR_IR;
        unique case (irOp)
          OP_LOAD: begin
            strobe.accLoad = 1'b1;
            strobe.pcInc   = 1'b1;
            nxtState       = ST_FETCH;
          end
          OP_ADD: begin
            strobe.accAdd = 1'b1;
            strobe.pcInc  = 1'b1;
            nxtState      = ST_FETCH;
          end
          OP_PRINT: begin
            strobe.outLoad = 1'b1;
            nxtState       = ST_OUTPUT;
          end
          default: begin
            strobe.pcInc = 1'b1;
            nxtState     = ST_FETCH;
          end
        endcase
      end
      ST_INPUT: begin
        strobe.addrSel = ADDR_IR;
        inReady = 1'b1;
        if (inValid) begin
          strobe.memWe    = 1'b1;
          strobe.wrFromIn = 1'b1;
          strobe.pcInc    = 1'b1;
          nxtState        = ST_FETCH;
        end
      end
      ST_OUTPUT: begin
        strobe.addrSel = ADDR_IR;
        outValid = 1'b1;
        if (outReady) begin
          strobe.pcInc = 1'b1;
          nxtState     = ST_FETCH;
        end
      end
      ST_HALT: begin
        strobe.addrSel = ADDR_IR;
        halted   = 1'b1;
        nxtState = ST_HALT;
      end
      default: nxtState = ST_FETCH;
    endcase
  end

endmodule

// File: rtl/accum_dpath.sv
module accum_dpath
  import accum_pkg::*;
#(
  parameter int              ADDR_W     = 12,
  parameter int              DATA_W     = 16,
  parameter logic [ADDR_W-1:0] START_ADDR = 12'h008
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] memRdata,
  input  logic [DATA_W-1:0] inData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] outData,
  output logic [OP_W-1:0]   fetchOp,
  output logic [OP_W-1:0]   irOp
);

  localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(1);

  logic [ADDR_W-1:0] pcReg;
  logic [DATA_W-1:0] irReg;
  logic [DATA_W-1:0] accReg;
  logic [DATA_W-1:0] outBuf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcReg  <= START_ADDR;
      irReg  <= '0;
      accReg <= '0;
      outBuf <= '0;
    end else begin
      if (strobe.pcInc)   pcReg  <= pcReg + PC_STEP;
      if (strobe.irLoad)  irReg  <= memRdata;
      if (strobe.accLoad) accReg <= memRdata;
      else if (strobe.accAdd) accReg <= accReg + memRdata;
      if (strobe.outLoad) outBuf <= memRdata;
    end
  end

  always_comb begin
    unique case (strobe.addrSel)
      ADDR_PC:      memAddr = pcReg;
      ADDR_FETCHED: memAddr = memRdata[ADDR_W-1:0];
      ADDR_IR:      memAddr = irReg[ADDR_W-1:0];
      default:      memAddr = pcReg;
    endcase
  end

  assign memWe    = strobe.memWe;
  assign memWdata = strobe.wrFromIn ? inData : accReg;
  assign outData  = outBuf;
  assign fetchOp  = memRdata[DATA_W-1 -: OP_W];
  assign irOp     = irReg[DATA_W-1 -: OP_W];

endmodule

// File: rtl/accum_core.sv
module accum_core
  import accum_pkg::*;
#(
  parameter int                ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] START_ADDR = 12'h008,
  localparam int               DATA_W     = OP_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData,
  output logic              halted
);

  ctrlStrobe_t     strobe;
  logic [OP_W-1:0] fetchOp;
  logic [OP_W-1:0] irOp;

  accum_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .fetchOp  (fetchOp),
    .irOp     (irOp),
    .inValid  (inValid),
    .outReady (outReady),
    .strobe   (strobe),
    .inReady  (inReady),
    .outValid (outValid),
    .halted   (halted)
  );

  accum_dpath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .START_ADDR (START_ADDR)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .memRdata (memRdata),
    .inData   (inData),
    .memAddr  (memAddr),
    .memWe    (memWe),
    .memWdata (memWdata),
    .outData  (outData),
    .fetchOp  (fetchOp),
    .irOp     (irOp)
  );

endmodule

// File: rtl/accum_core_chk.sv
module accum_core_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memWe,
  input logic              inValid,
  input logic              inReady,
  input logic              outValid,
  input logic              outReady,
  input logic [DATA_W-1:0] outData,
  input logic              halted
);

  p_in_wait_r6: assert property (@(posedge clk) disable iff (!rstN)
    (inReady && !inValid) |=> (inReady && $stable(memAddr)));

  p_in_nowrite_r6: assert property (@(posedge clk) disable iff (!rstN)
    (inReady && !inValid) |-> !memWe);

  p_in_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    (inReady && inValid) |-> memWe);

  p_stall_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({inReady, outValid, halted}));

  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  p_halt_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted);

  p_halt_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> (!memWe && !outValid && !inReady));

  p_halt_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    (halted && $past(halted)) |-> $stable(memAddr));

endmodule

bind accum_core accum_core_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .memAddr  (memAddr),
  .memWe    (memWe),
  .inValid  (inValid),
  .inReady  (inReady),
  .outValid (outValid),
  .outReady (outReady),
  .outData  (outData),
  .halted   (halted)
);

// File: tb/tb_accum_core.sv
`timescale 1ns/1ps
module tb_accum_core;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] memAddr;
  logic        memWe;
  logic [15:0] memWdata;
  logic [15:0] memRdata;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [15:0] inData = '0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [15:0] outData;
  logic        halted;

  always #2.5 clk = ~clk;

  accum_core dut (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memWe(memWe),
    .memWdata(memWdata), .memRdata(memRdata), .inValid(inValid),
    .inReady(inReady), .inData(inData), .outValid(outValid),
    .outReady(outReady), .outData(outData), .halted(halted)
  );

  logic [15:0] mem [4096];
  always @(posedge clk) begin
    if (memWe) mem[memAddr] <= memWdata;
    memRdata <= mem[memAddr];
  end

  int checks = 0;
  int errors = 0;

  logic [15:0] inQ [8];
  int          inNum;
  logic [15:0] printLog [8];
  int          printCnt;
  int          stallErr;
  int          holdErr;

  // {a, b, c, expected sum, input delay, output delay}
  localparam logic [95:0] VEC [6] = '{
    {16'h0001, 16'h0002, 16'h0003, 16'h0006, 16'd0, 16'd0},
    {16'hFFFF, 16'h0001, 16'h0001, 16'h0001, 16'd3, 16'd2},
    {16'h8000, 16'h8000, 16'h0005, 16'h0005, 16'd0, 16'd5},
    {16'h1234, 16'h0000, 16'hABCD, 16'hBE01, 16'd7, 16'd0},
    {16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'd1, 16'd1},
    {16'h7FFF, 16'h7FFF, 16'h0002, 16'h0000, 16'd4, 16'd9}
  };

  task automatic chkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    inValid = 1'b0;
    outReady = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic runProg(input int inDly, input int outDly, input int limit);
    int inIdx = 0;
    int inWait = 0;
    int outWait = 0;
    logic [11:0] stallAddr = '0;
    logic [15:0] outHeld = '0;
    printCnt = 0;
    stallErr = 0;
    holdErr = 0;
    for (int cyc = 0; cyc < limit && !halted; cyc++) begin
      @(negedge clk);
      if (inValid) begin inIdx++; inValid = 1'b0; inWait = 0; end
      if (outReady) begin outReady = 1'b0; outWait = 0; end
      if (inReady) begin
        if (inWait == 0) stallAddr = memAddr;
        else if (memWe || memAddr != stallAddr) stallErr++;
        if (inWait >= inDly && inIdx < inNum) begin
          inValid = 1'b1;
          inData = inQ[inIdx];
        end else inWait++;
      end
      if (outValid) begin
        if (outWait == 0) outHeld = outData;
        else if (outData != outHeld) holdErr++;
        if (outWait >= outDly) begin
          outReady = 1'b1;
          if (printCnt < 8) printLog[printCnt] = outData;
          printCnt++;
        end else outWait++;
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state and first fetch address
    clearMem();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chkEq("R1 halted in reset", halted, 0);
    chkEq("R1 inReady in reset", inReady, 0);
    chkEq("R1 outValid in reset", outValid, 0);
    chkEq("R1 memWe in reset", memWe, 0);
    rstN = 1'b1;
    #1;
    chkEq("R1 first fetch address", memAddr, 12'h008);
    chkEq("R1 no write on first cycle", memWe, 0);

    // R2 R3 R4 R5 R6 R7 R8: sum program over the vector table
    for (int v = 0; v < 6; v++) begin
      logic [95:0] row;
      row = VEC[v];
      clearMem();
      mem[12'h008] = 16'hA200;
      mem[12'h009] = 16'hA201;
      mem[12'h00A] = 16'hA202;
      mem[12'h00B] = 16'h1200;
      mem[12'h00C] = 16'h2201;
      mem[12'h00D] = 16'h2202;
      mem[12'h00E] = 16'h6204;
      mem[12'h00F] = 16'hB204;
      mem[12'h010] = 16'hF000;
      inQ[0] = row[95:80];
      inQ[1] = row[79:64];
      inQ[2] = row[63:48];
      inNum = 3;
      doReset();
      runProg(int'(row[31:16]), int'(row[15:0]), 400);
      chkEq("R8 program halts", halted, 1);
      chkEq("R6 stored input a", mem[12'h200], row[95:80]);
      chkEq("R6 stored input c", mem[12'h202], row[63:48]);
      chkEq("R6 no fetch or write during input stall", stallErr, 0);
      chkEq("R4 stored wrapped sum", mem[12'h204], row[47:32]);
      chkEq("R7 one word printed", printCnt, 1);
      chkEq("R7 printed sum", printLog[0], row[47:32]);
      chkEq("R7 output held during stall", holdErr, 0);
    end

    // R3 R5: store keeps accumulator, load discards old contents
    clearMem();
    mem[12'h100] = 16'h5A5A;
    mem[12'h101] = 16'h0003;
    mem[12'h008] = 16'h1100;
    mem[12'h009] = 16'h6110;
    mem[12'h00A] = 16'h6111;
    mem[12'h00B] = 16'h2100;
    mem[12'h00C] = 16'h6112;
    mem[12'h00D] = 16'h1101;
    mem[12'h00E] = 16'h6113;
    mem[12'h00F] = 16'hB111;
    mem[12'h010] = 16'hF000;
    inNum = 0;
    doReset();
    runProg(0, 3, 400);
    chkEq("R5 first store", mem[12'h110], 16'h5A5A);
    chkEq("R5 second store sees same accumulator", mem[12'h111], 16'h5A5A);
    chkEq("R4 add after stores", mem[12'h112], 16'hB4B4);
    chkEq("R3 load replaces accumulator", mem[12'h113], 16'h0003);
    chkEq("R7 print of stored word", printLog[0], 16'h5A5A);

    // R9: unlisted codes change nothing but the program counter
    clearMem();
    mem[12'h100] = 16'h0042;
    mem[12'h120] = 16'h7777;
    mem[12'h008] = 16'h1100;
    mem[12'h009] = 16'h0120;
    mem[12'h00A] = 16'h3120;
    mem[12'h00B] = 16'h7120;
    mem[12'h00C] = 16'hC120;
    mem[12'h00D] = 16'hE120;
    mem[12'h00E] = 16'h6121;
    mem[12'h00F] = 16'hB120;
    mem[12'h010] = 16'hF000;
    inNum = 0;
    doReset();
    runProg(0, 0, 400);
    chkEq("R9 operand word untouched", mem[12'h120], 16'h7777);
    chkEq("R9 accumulator unchanged", mem[12'h121], 16'h0042);
    chkEq("R9 execution continued to print", printCnt, 1);
    chkEq("R9 halted after no-ops", halted, 1);

    // R8: halt ignores its operand and stays halted
    clearMem();
    mem[12'hFFF] = 16'hC0DE;
    mem[12'h008] = 16'hFFFF;
    inNum = 0;
    doReset();
    runProg(0, 0, 50);
    chkEq("R8 halted with nonzero operand", halted, 1);
    begin
      int quietErr = 0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (!halted || memWe || outValid || inReady) quietErr++;
      end
      chkEq("R8 stays halted and quiet", quietErr, 0);
    end
    chkEq("R8 operand address untouched", mem[12'hFFF], 16'hC0DE);
    rstN = 1'b0;
    #1;
    chkEq("R1 reset clears halted", halted, 0);
    @(negedge clk);

    // R2 R6: input write and program counter advance on the same edge
    clearMem();
    mem[12'h300] = 16'hBEEF;
    mem[12'h008] = 16'hA009;
    mem[12'h009] = 16'h0000;
    mem[12'h00A] = 16'hF000;
    inQ[0] = 16'hB300;
    inNum = 1;
    doReset();
    runProg(2, 1, 200);
    chkEq("R2 freshly read instruction executed", printCnt, 1);
    chkEq("R2 printed word from overwritten slot", printLog[0], 16'hBEEF);
    chkEq("R6 instruction word landed in memory", mem[12'h009], 16'hB300);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule